// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Port Sequencer

This block is the digital side of an oversampling converter's serial port. It runs on a fast system clock and steps through three states: converting, sleep and data output. A host controls it with an active-low chip select, an external serial clock and a serial data input, and it answers on a serial data output with an output enable, a busy flag and an end-of-conversion flag. The result of each conversion arrives on a parallel word and is sent out as a fixed 32-bit frame.

All three host pins are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are detected in the system clock domain. While the host reads a frame, the first five rising clock edges also load a 5-bit oversampling code from the data input. The code sets how long the next conversion lasts, counted as the oversampling ratio times a base number of system cycles.

The parallel sample has no handshake and cannot exert back-pressure. It is read in the single cycle when a conversion ends, so the source must hold it stable across that cycle.

Top module: `adc_serial_port`

## Requirements
- R1: During and after reset, busy and end-of-conversion are high and a conversion of 256 times BASE_CYCLES system cycles is in progress.
- R2: With chip select high, the output enable is low. With chip select low, the output enable is high, and the data output reads 1 while converting and 0 while in sleep.
- R3: When a conversion ends, the block enters sleep with busy and end-of-conversion low, whatever the level of chip select. Clock edges that arrive while chip select is high are ignored. Sleep ends only on a rising serial clock edge with chip select low.
- R4: The frame is 32 bits and advances on each falling serial clock edge. Its bits are sent in this order:
  - a 0 for end-of-conversion;
  - a fixed 0;
  - bits 29 down to 0 of the sample, with bit 29 as the sign.
  Sample bits 31 and 30 are ignored.
- R5: On the 32nd falling serial clock edge of a readout, a new conversion starts: busy and end-of-conversion go high and the data output reads 1.
- R6: A rising chip select edge after at least five falling clock edges of a readout aborts the readout and starts a new conversion at once.
- R7: A rising chip select edge before the fifth falling clock edge is ignored. The readout stays in data output and resumes at the same bit.
- R8: The oversampling code is taken MSB first on the first five rising clock edges of a readout, counting the edge that ends sleep. It decodes as follows:
  - if the low four bits n are 1 to 9, the ratio is 2^(5+n) and bit 4 is ignored;
  - code 11111 gives a ratio of 32768;
  - code 00000 gives a ratio of 256.
- R9: Any other code leaves the previously selected ratio unchanged.
- R10: A conversion lasts exactly ratio times BASE_CYCLES system cycles, measured as the cycles with busy high. A ratio captured during a readout applies to the conversion that the end or abort of that readout starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | External serial clock, asynchronous |
| sdi_i | input | 1 | Serial data input carrying the oversampling code |
| sample_i | input | 32 | Parallel conversion result, read when a conversion ends |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the serial data output (tristate control) |
| busy_o | output | 1 | High while converting |
| eoc_o | output | 1 | End-of-conversion flag: high while converting, low once the result is ready |

## Verification
The bound checker verifies these rules on every cycle:
- the data output reads 1 whenever it is enabled during a conversion;
- busy falls only on a timer expiry;
- sleep never returns straight to converting;
- busy rises only out of data output;
- an abort never happens before the fifth falling edge;
- the data output holds between accepted falling edges;
- the falling-edge count stays inside the frame.

Only the bench scenarios can show the rest. These are:
- the frame contents for a given sample;
- the decoding of each oversampling code, including the codes that are ignored;
- the exact conversion lengths;
- a chip select toggle that is ignored early in the readout versus one that aborts it.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } adc_state_e;

  localparam int OSR_CODE_W  = 5;
  localparam int OSR_SHIFT_W = 4;
  localparam int OSR_MAX_SHIFT   = 15;
  localparam int OSR_RESET_SHIFT = 8;

  // Returns {valid, log2(ratio)} for a captured 5-bit code.
  function automatic logic [OSR_SHIFT_W:0] osr_decode(input logic [OSR_CODE_W-1:0] code);
    logic [OSR_SHIFT_W:0] res;
    res = '0;
    if (code == 5'b11111) begin
      res = {1'b1, 4'd15};
    end else if (code == 5'b00000) begin
      res = {1'b1, 4'd8};
    end else if (code[3:0] >= 4'd1 && code[3:0] <= 4'd9) begin
      res = {1'b1, code[3:0] + 4'd5};
    end
    return res;
  endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_sp_osr.sv
module adc_sp_osr
  import adc_sp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   arm_i,
  input  logic                   rise_i,
  input  logic                   sdi_i,
  output logic [OSR_SHIFT_W-1:0] shift_o
);
  localparam int CNT_W = $clog2(OSR_CODE_W + 1);

  logic [CNT_W-1:0]        cnt_q;
  logic [OSR_CODE_W-2:0]   code_q;
  logic [OSR_SHIFT_W-1:0]  shift_q;
  logic [OSR_SHIFT_W:0]    dec;

  assign dec = osr_decode({code_q, sdi_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      code_q  <= '0;
      shift_q <= OSR_SHIFT_W'(OSR_RESET_SHIFT);
    end else if (!arm_i) begin
      cnt_q <= '0;
    end else if (rise_i && cnt_q < CNT_W'(OSR_CODE_W)) begin
      cnt_q  <= cnt_q + CNT_W'(1);
      code_q <= {code_q[OSR_CODE_W-3:0], sdi_i};
      if (cnt_q == CNT_W'(OSR_CODE_W - 1) && dec[OSR_SHIFT_W]) begin
        shift_q <= dec[OSR_SHIFT_W-1:0];
      end
    end
  end

  assign shift_o = shift_q;
endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer
  import adc_sp_pkg::*;
#(
  parameter int BASE_CYCLES = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [OSR_SHIFT_W-1:0] shift_i,
  output logic                   done_o
);
  localparam int CNT_W = $clog2(BASE_CYCLES + 1) + OSR_MAX_SHIFT + 1;
  localparam logic [CNT_W-1:0] RESET_LOAD =
    (CNT_W'(BASE_CYCLES) << OSR_RESET_SHIFT) - CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = (CNT_W'(BASE_CYCLES) << shift_i) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RESET_LOAD;
      run_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/adc_sp_frame.sv
module adc_sp_frame #(
  parameter int FRAME_W = 32,
  parameter int HDR_W = 2,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] sample_i,
  input  logic               shift_i,
  output logic               msb_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [FRAME_W-1:0] KEEP = {{HDR_W{1'b0}}, {(FRAME_W-HDR_W){1'b1}}};

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= sample_i & KEEP;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign msb_o = sh_q[FRAME_W-1];
  assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int BASE_CYCLES = 1,
  parameter int FRAME_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ABORT_FALLS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] sample_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic               busy_o,
  output logic               eoc_o
);
  localparam int FCNT_W = $clog2(FRAME_W + 1);
  localparam logic [FCNT_W-1:0] LAST_FALL = FCNT_W'(FRAME_W - 1);
  localparam logic [FCNT_W-1:0] MIN_ABORT = FCNT_W'(ABORT_FALLS);

  // Synchronized pins: [2] data in, [1] serial clock, [0] chip select (active low)
  logic [2:0] pins_s;
  adc_sp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdi_i, sck_i, cs_n_i}),
    .sync_o  (pins_s)
  );

  logic sck_q, csn_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      csn_q <= 1'b1;
    end else begin
      sck_q <= pins_s[1];
      csn_q <= pins_s[0];
    end
  end

  logic cs_lo, sck_rise_ok, sck_fall_ok, cs_rise;
  assign cs_lo       = ~pins_s[0];
  assign sck_rise_ok = pins_s[1] & ~sck_q & cs_lo;
  assign sck_fall_ok = ~pins_s[1] & sck_q & cs_lo;
  assign cs_rise     = pins_s[0] & ~csn_q;

  adc_state_e state_q, st_d;
  logic              conv_done, start_conv, frame_msb;
  logic [FCNT_W-1:0] fall_cnt;
  logic [OSR_SHIFT_W-1:0] next_shift;

  always_comb begin
    st_d = state_q;
    case (state_q)
      ST_CONV:  if (conv_done) st_d = ST_SLEEP;
      ST_SLEEP: if (sck_rise_ok) st_d = ST_OUT;
      ST_OUT: begin
        if (sck_fall_ok && fall_cnt == LAST_FALL)   st_d = ST_CONV;
        else if (cs_rise && fall_cnt >= MIN_ABORT)  st_d = ST_CONV;
      end
      default: st_d = ST_CONV;
    endcase
  end

  assign start_conv = (state_q == ST_OUT) && (st_d == ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CONV;
    else        state_q <= st_d;
  end

  adc_sp_osr u_osr (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (state_q != ST_CONV),
    .rise_i  (sck_rise_ok),
    .sdi_i   (pins_s[2]),
    .shift_o (next_shift)
  );

  adc_sp_timer #(.BASE_CYCLES(BASE_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_conv),
    .shift_i (next_shift),
    .done_o  (conv_done)
  );

  adc_sp_frame #(.FRAME_W(FRAME_W), .HDR_W(2)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (conv_done && state_q == ST_CONV),
    .sample_i (sample_i),
    .shift_i  (sck_fall_ok && state_q == ST_OUT),
    .msb_o    (frame_msb),
    .cnt_o    (fall_cnt)
  );

  assign busy_o   = (state_q == ST_CONV);
  assign eoc_o    = (state_q == ST_CONV);
  assign sdo_o    = (state_q == ST_CONV) ? 1'b1 : frame_msb;
  assign sdo_oe_o = cs_lo;
endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk
  import adc_sp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       sdo_o,
  input logic       sdo_oe_o,
  input adc_state_e state_q,
  input logic       conv_done,
  input logic       sck_fall_ok,
  input logic [5:0] fall_cnt
);
  AST_CONV_SDO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sdo_oe_o) |-> sdo_o); // R2

  AST_SLEEP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(conv_done)); // R3

  AST_SLEEP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP) |=> (state_q != ST_CONV)); // R3

  AST_BUSY_FROM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(state_q) == ST_OUT)); // R5

  AST_ABORT_LATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy_o) && !$past(sck_fall_ok)) |-> ($past(fall_cnt) >= 6'd5)); // R6

  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OUT && $past(state_q) == ST_OUT && !$past(sck_fall_ok)) |-> $stable(sdo_o)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OUT) |-> (fall_cnt < 6'd32)); // R4
endmodule

bind adc_serial_port adc_sp_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .state_q     (state_q),
  .conv_done   (conv_done),
  .sck_fall_ok (sck_fall_ok),
  .fall_cnt    (fall_cnt)
);

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;
  localparam int BASE = 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic [31:0] sample = '0;
  logic        sdo, sdo_oe, busy, eoc;

  adc_serial_port #(.BASE_CYCLES(BASE)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n),
    .sck_i    (sck),
    .sdi_i    (sdi),
    .sample_i (sample),
    .sdo_o    (sdo),
    .sdo_oe_o (sdo_oe),
    .busy_o   (busy),
    .eoc_o    (eoc)
  );

  // {code[4:0], sample[31:0], expected log2 ratio[3:0]}
  localparam logic [40:0] VEC [9] = '{
    {5'b00001, 32'hC123_4567, 4'd6},
    {5'b00010, 32'h7FFF_FFFF, 4'd7},
    {5'b10011, 32'h2000_0001, 4'd8},
    {5'b00100, 32'h1555_AAAA, 4'd9},
    {5'b01001, 32'hA5A5_A5A5, 4'd14},
    {5'b01010, 32'h0000_0000, 4'd14},
    {5'b10000, 32'hFFFF_FFFF, 4'd14},
    {5'b00000, 32'h3C3C_0F0F, 4'd8},
    {5'b11111, 32'h1111_2222, 4'd15}
  };
  localparam logic [31:0] TAIL_SAMPLE = 32'h1234_5678;

  int n_checks = 0;
  int n_fail = 0;
  int run_cnt = 0;
  int last_len = 0;
  logic got_bit;
  logic [31:0] word;

  always @(negedge clk) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else if (run_cnt != 0) begin
      last_len <= run_cnt;
      run_cnt  <= 0;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    sdi = b;
    idle(8);
    sck = 1'b1;
    idle(8);
    got_bit = sdo;
    sck = 1'b0;
  endtask

  task automatic wait_sleep();
    while (busy !== 1'b0) @(negedge clk);
    idle(2);
  endtask

  task automatic read_frame(input logic [4:0] code);
    cs_n = 1'b0;
    idle(8);
    for (int i = 0; i < 32; i++) begin
      pulse(i < 5 ? code[4-i] : 1'b0);
      word[31-i] = got_bit;
    end
    idle(8);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    sample = VEC[0][35:4];
    idle(3);
    check("R1 busy in reset", busy, 1);
    check("R1 eoc in reset", eoc, 1);
    check("R2 oe low with cs high", sdo_oe, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    idle(10);
    cs_n = 1'b0;
    idle(6);
    check("R2 oe with cs low", sdo_oe, 1);
    check("R2 sdo during conversion", sdo, 1);
    cs_n = 1'b1;
    idle(6);
    check("R2 oe after cs high", sdo_oe, 0);

    wait_sleep();
    check("R1 reset conversion length", last_len, 256 * BASE);
    check("R3 eoc low in sleep", eoc, 0);

    // Table walk: R4 frame, R5 restart, R8/R9 decode, R10 length
    for (int k = 0; k < 9; k++) begin
      read_frame(VEC[k][40:36]);
      check("R4 frame word", word, {2'b00, VEC[k][33:4]});
      check("R5 busy after frame", busy, 1);
      check("R5 eoc after frame", eoc, 1);
      check("R5 sdo during conversion", sdo, 1);
      sample = (k < 8) ? VEC[k+1][35:4] : TAIL_SAMPLE;
      cs_n = 1'b1;
      wait_sleep();
      if (k == 5 || k == 6)
        check("R9 invalid code keeps ratio", last_len, BASE << VEC[k][3:0]);
      else
        check("R8 R10 decoded length", last_len, BASE << VEC[k][3:0]);
    end

    // R3: clock edges with chip select high leave sleep untouched
    for (int j = 0; j < 3; j++) begin
      sck = 1'b1; idle(8);
      sck = 1'b0; idle(8);
    end
    check("R3 stays in sleep", busy, 0);
    idle(100);
    check("R3 no spontaneous start", busy, 0);
    cs_n = 1'b0;
    idle(8);
    check("R2 oe in sleep", sdo_oe, 1);
    check("R2 sdo in sleep", sdo, 0);

    // R7: early chip select toggle is ignored
    pulse(1'b0); pulse(1'b0); pulse(1'b0);
    idle(8);
    cs_n = 1'b1;
    idle(8);
    check("R7 early cs rise ignored", busy, 0);
    cs_n = 1'b0;
    idle(8);
    check("R7 readout resumes at bit 3", sdo, TAIL_SAMPLE[28]);
    pulse(1'b0); pulse(1'b1);
    idle(8);
    // R6: abort after five falls
    cs_n = 1'b1;
    idle(8);
    check("R6 abort starts conversion", busy, 1);
    wait_sleep();
    check("R6 R10 aborted readout ratio", last_len, 64 * BASE);

    finish_run();
  end
endmodule